// File: doc/BRIEF.md
# SPI Flash Upload Capture Buffer

This block sits on the device side of a serial-flash emulation path and captures program commands sent by the host. The serial bytes arrive already deserialized, as a byte stream qualified by a chip-select level. When the first byte of a selection matches the configured upload opcode, that opcode is queued in a command FIFO. The following three or four address bytes are assembled most-significant first and queued in a 32-bit address FIFO. Every later byte in the same selection is written into a circular payload region of a word-wide buffer memory.

A transfer longer than the region overwrites the oldest bytes. The block then raises an overflow flag, saturates the byte depth at the region size and reports the byte index of the oldest retained byte. The system side can then read the most recent bytes back in order. It reads from that index to the end of the region, then continues from word zero. Selections that begin with any other opcode are ignored in full.

The byte input and both FIFO outputs are valid/ready streams. A byte is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is low while chip select is inactive. While the opcode is expected, it is also low whenever either FIFO is full; the opcode is held, not dropped, until room appears. A FIFO entry leaves on an edge where its valid and ready are both high. Valid and data hold steady while ready is low. The payload status outputs are only meaningful to software after chip select has gone inactive.

Top module: `upload_capture`

## Requirements
- R1: After reset both FIFOs are empty with count 0, `pl_depth_o` is 0, `pl_start_o` is 0 and `pl_overflow_o` is 0.
- R2: A first byte equal to 0x02 is pushed into the command FIFO. A selection whose first byte is any other value changes neither FIFO nor any payload output.
- R3: With `addr4b_en_i` low, three address bytes follow the opcode and are pushed zero-extended. With it high, four bytes follow. The first address byte received is the most significant.
- R4: When a command carries at most 256 payload bytes, `pl_overflow_o` is 0, `pl_start_o` is 0 and `pl_depth_o` equals the number of bytes received.
- R5: When a command carries N > 256 payload bytes, `pl_overflow_o` is 1, `pl_depth_o` is 256 and `pl_start_o` is N mod 256.
- R6: Payload byte N is stored in word (N mod 256)/4, in bits [8*(N mod 4)+7 : 8*(N mod 4)]. Reading 256-or-depth bytes from `pl_start_o` onward, wrapping at 256, yields the last received bytes in arrival order.
- R7: Accepting a new upload opcode clears the payload depth, start index and overflow flag.
- R8: While the opcode is expected, `in_ready_o` is low if either FIFO holds its full depth (4). The waiting byte is accepted once an entry is popped.
- R9: Each FIFO pops on valid and ready, keeps arrival order and reports an occupancy from 0 to its depth. Valid and data stay stable while ready is low.
- R10: Chip select going inactive returns the parser to the opcode phase. An address cut short is not pushed.
- R11: `pl_rd_data_o` shows the word at `pl_rd_addr_i` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_active_i | input | 1 | High while the host selects the device |
| addr4b_en_i | input | 1 | Selects four address bytes instead of three |
| in_valid_i | input | 1 | Received byte valid |
| in_ready_o | output | 1 | Block can take the byte |
| in_data_i | input | 8 | Received byte |
| cmd_valid_o | output | 1 | Command FIFO not empty |
| cmd_ready_i | input | 1 | Pop command FIFO head |
| cmd_data_o | output | 8 | Command FIFO head opcode |
| cmd_count_o | output | 3 | Command FIFO occupancy |
| addr_valid_o | output | 1 | Address FIFO not empty |
| addr_ready_i | input | 1 | Pop address FIFO head |
| addr_data_o | output | 32 | Address FIFO head |
| addr_count_o | output | 3 | Address FIFO occupancy |
| pl_rd_addr_i | input | 6 | Payload word read address |
| pl_rd_data_o | output | 32 | Payload word, one cycle after the address |
| pl_depth_o | output | 9 | Retained payload bytes |
| pl_start_o | output | 8 | Byte index of the oldest retained byte |
| pl_overflow_o | output | 1 | More bytes arrived than the region holds |

## Verification
Payloads of 255, 256, 300 and 600 bytes separate the no-wrap case, the exact-fill boundary, a single wrap and a multiple wrap. Each one is read back through the word port and compared against the tail of what was sent. A five-byte payload exercises the lane placement inside a partly filled word. Three- and four-byte addresses, a foreign opcode and a selection cut off inside the address phase show that parsing follows the address width, ignores other commands and restarts on deselect. Filling both FIFOs and then popping one entry shows that the opcode waits under back-pressure and is not lost.

// File: rtl/upl_pkg.sv
package upl_pkg;
  typedef enum logic [1:0] {
    PH_OP   = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;
endpackage : upl_pkg

// File: rtl/upl_fifo.sv
module upl_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  output logic          pop_valid_o,
  input  logic          pop_ready_i,
  output logic [W-1:0]  pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic [CW-1:0] cnt;
  logic          pop;

  assign pop         = pop_valid_o && pop_ready_i;
  assign pop_valid_o = (cnt != '0);
  assign pop_data_o  = store[rptr];
  assign count_o     = cnt;
  assign full_o      = (cnt == CW'(DEPTH));

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_i) wptr <= nxt(wptr);
      if (pop)    rptr <= nxt(rptr);
      if (push_i && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push_i) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) store[wptr] <= push_data_i;
  end
endmodule : upl_fifo

// File: rtl/upl_payload.sv
module upl_payload #(
  parameter int unsigned PL_BYTES   = 256,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned PL_WORDS  = PL_BYTES / WORD_BYTES,
  localparam int unsigned WAW       = $clog2(PL_WORDS),
  localparam int unsigned BIW       = $clog2(PL_BYTES),
  localparam int unsigned OFFW      = $clog2(WORD_BYTES),
  localparam int unsigned DEPW      = $clog2(PL_BYTES + 1),
  localparam int unsigned DW        = 8 * WORD_BYTES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            wr_valid_i,
  input  logic [7:0]      wr_byte_i,
  input  logic [WAW-1:0]  rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [DEPW-1:0] depth_o,
  output logic [BIW-1:0]  start_o,
  output logic            overflow_o
);
  logic [DW-1:0]         mem [PL_WORDS];
  logic [BIW-1:0]        wptr;
  logic [DEPW-1:0]       depth;
  logic                  ovf;
  logic [WORD_BYTES-1:0] strb;
  logic [WAW-1:0]        widx;

  assign widx = wptr[BIW-1:OFFW];

  always_comb begin
    strb = '0;
    if (wr_valid_i) strb[wptr[OFFW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      depth <= '0;
      ovf   <= 1'b0;
    end else if (clear_i) begin
      wptr  <= '0;
      depth <= '0;
      ovf   <= 1'b0;
    end else if (wr_valid_i) begin
      wptr <= wptr + 1'b1;
      if (depth == DEPW'(PL_BYTES)) ovf <= 1'b1;
      else                          depth <= depth + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < WORD_BYTES; l++) begin
      if (strb[l]) mem[widx][8*l +: 8] <= wr_byte_i;
    end
    rd_data_o <= mem[rd_addr_i];
  end

  assign depth_o    = depth;
  assign overflow_o = ovf;
  assign start_o    = ovf ? wptr : '0;
endmodule : upl_payload

// File: rtl/upload_capture.sv
module upload_capture #(
  parameter logic [7:0]  UPLOAD_OP  = 8'h02,
  parameter int unsigned CMD_DEPTH  = 4,
  parameter int unsigned ADDR_DEPTH = 4,
  parameter int unsigned PL_BYTES   = 256,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    cs_active_i,
  input  logic                                    addr4b_en_i,
  input  logic                                    in_valid_i,
  output logic                                    in_ready_o,
  input  logic [7:0]                              in_data_i,
  output logic                                    cmd_valid_o,
  input  logic                                    cmd_ready_i,
  output logic [7:0]                              cmd_data_o,
  output logic [$clog2(CMD_DEPTH+1)-1:0]          cmd_count_o,
  output logic                                    addr_valid_o,
  input  logic                                    addr_ready_i,
  output logic [31:0]                             addr_data_o,
  output logic [$clog2(ADDR_DEPTH+1)-1:0]         addr_count_o,
  input  logic [$clog2(PL_BYTES/WORD_BYTES)-1:0]  pl_rd_addr_i,
  output logic [8*WORD_BYTES-1:0]                 pl_rd_data_o,
  output logic [$clog2(PL_BYTES+1)-1:0]           pl_depth_o,
  output logic [$clog2(PL_BYTES)-1:0]             pl_start_o,
  output logic                                    pl_overflow_o
);
  import upl_pkg::*;

  phase_e      st;
  logic [2:0]  addr_left;
  logic [31:0] addr_sh;
  logic        cmd_full, addr_full;
  logic        accept, cmd_push, addr_push, pl_write;

  assign in_ready_o = cs_active_i && ((st != PH_OP) || (!cmd_full && !addr_full));
  assign accept     = in_valid_i && in_ready_o;
  assign cmd_push   = accept && (st == PH_OP) && (in_data_i == UPLOAD_OP);
  assign addr_push  = accept && (st == PH_ADDR) && (addr_left == 3'd1);
  assign pl_write   = accept && (st == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= PH_OP;
      addr_left <= '0;
      addr_sh   <= '0;
    end else if (!cs_active_i) begin
      st <= PH_OP;
    end else if (accept) begin
      unique case (st)
        PH_OP: begin
          if (in_data_i == UPLOAD_OP) begin
            st        <= PH_ADDR;
            addr_left <= addr4b_en_i ? 3'd4 : 3'd3;
            addr_sh   <= '0;
          end else begin
            st <= PH_SKIP;
          end
        end
        PH_ADDR: begin
          addr_sh   <= {addr_sh[23:0], in_data_i};
          addr_left <= addr_left - 1'b1;
          if (addr_left == 3'd1) st <= PH_DATA;
        end
        default: st <= st;
      endcase
    end
  end

  upl_fifo #(.W(8), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (cmd_push),
    .push_data_i (in_data_i),
    .pop_valid_o (cmd_valid_o),
    .pop_ready_i (cmd_ready_i),
    .pop_data_o  (cmd_data_o),
    .count_o     (cmd_count_o),
    .full_o      (cmd_full)
  );

  upl_fifo #(.W(32), .DEPTH(ADDR_DEPTH)) u_addr_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (addr_push),
    .push_data_i ({addr_sh[23:0], in_data_i}),
    .pop_valid_o (addr_valid_o),
    .pop_ready_i (addr_ready_i),
    .pop_data_o  (addr_data_o),
    .count_o     (addr_count_o),
    .full_o      (addr_full)
  );

  upl_payload #(.PL_BYTES(PL_BYTES), .WORD_BYTES(WORD_BYTES)) u_payload (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (cmd_push),
    .wr_valid_i (pl_write),
    .wr_byte_i  (in_data_i),
    .rd_addr_i  (pl_rd_addr_i),
    .rd_data_o  (pl_rd_data_o),
    .depth_o    (pl_depth_o),
    .start_o    (pl_start_o),
    .overflow_o (pl_overflow_o)
  );
endmodule : upload_capture

// File: rtl/upload_capture_chk.sv
module upload_capture_chk #(
  parameter int unsigned CMD_DEPTH  = 4,
  parameter int unsigned ADDR_DEPTH = 4,
  parameter int unsigned PL_BYTES   = 256
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               cmd_valid_o,
  input logic                               cmd_ready_i,
  input logic [7:0]                         cmd_data_o,
  input logic [$clog2(CMD_DEPTH+1)-1:0]     cmd_count_o,
  input logic [$clog2(ADDR_DEPTH+1)-1:0]    addr_count_o,
  input logic [$clog2(PL_BYTES+1)-1:0]      pl_depth_o,
  input logic [$clog2(PL_BYTES)-1:0]        pl_start_o,
  input logic                               pl_overflow_o
);
  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (cmd_count_o == '0 && addr_count_o == '0 &&
                        pl_depth_o == '0 && !pl_overflow_o));

  p_start_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pl_overflow_o |-> (pl_start_o == '0));

  p_ovf_saturate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_overflow_o |-> (pl_depth_o == ($clog2(PL_BYTES+1))'(PL_BYTES)));

  p_depth_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_depth_o > $past(pl_depth_o)) |-> (pl_depth_o == $past(pl_depth_o) + 1'b1));

  p_cmd_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_count_o <= ($clog2(CMD_DEPTH+1))'(CMD_DEPTH));

  p_addr_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_count_o <= ($clog2(ADDR_DEPTH+1))'(ADDR_DEPTH));

  p_cmd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o)));
endmodule : upload_capture_chk

bind upload_capture upload_capture_chk #(
  .CMD_DEPTH (CMD_DEPTH),
  .ADDR_DEPTH(ADDR_DEPTH),
  .PL_BYTES  (PL_BYTES)
) u_chk (.*);

// File: tb/upload_capture_tb.sv
module upload_capture_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs = 1'b0, a4 = 1'b0, in_valid = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [7:0]  cmd_data;
  logic [2:0]  cmd_count, addr_count;
  logic        addr_valid, addr_ready = 1'b0;
  logic [31:0] addr_data;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [8:0]  depth;
  logic [7:0]  start;
  logic        ovf;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int          mst = 0, mleft = 0, mcnt = 0;
  logic [31:0] msh = '0;
  logic [7:0]  cmdq[$];
  logic [31:0] addrq[$];
  logic [7:0]  sent[$];

  always #10 clk = ~clk;

  upload_capture u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_active_i(cs), .addr4b_en_i(a4),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data),
    .cmd_count_o(cmd_count), .addr_valid_o(addr_valid), .addr_ready_i(addr_ready),
    .addr_data_o(addr_data), .addr_count_o(addr_count), .pl_rd_addr_i(rd_addr),
    .pl_rd_data_o(rd_data), .pl_depth_o(depth), .pl_start_o(start),
    .pl_overflow_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FIFO check FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_depth(); return (mcnt > 256) ? 256 : mcnt; endfunction
  function automatic int m_start(); return (mcnt > 256) ? (mcnt % 256) : 0; endfunction

  function automatic void model_byte(input logic [7:0] b);
    case (mst)
      0: if (b == 8'h02) begin
           cmdq.push_back(b); mst = 1; mleft = a4 ? 4 : 3; msh = '0; mcnt = 0; sent = {};
         end else mst = 3;
      1: begin
           msh = {msh[23:0], b}; mleft--;
           if (mleft == 0) begin addrq.push_back(msh); mst = 2; end
         end
      2: begin sent.push_back(b); mcnt++; end
      default: ;
    endcase
  endfunction

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_ni && !done) begin
      chk(in_ready == (cs && (mst != 0 || (cmdq.size() < 4 && addrq.size() < 4))),
          "R8 in_ready", in_ready, 0);
      chk(cmd_count == cmdq.size(), "R9 cmd_count", cmd_count, cmdq.size());
      chk(addr_count == addrq.size(), "R9 addr_count", addr_count, addrq.size());
      chk(cmd_valid == (cmdq.size() > 0), "R9 cmd_valid", cmd_valid, cmdq.size() > 0);
      if (cmdq.size() > 0) chk(cmd_data == cmdq[0], "R2 cmd head", cmd_data, cmdq[0]);
      if (addrq.size() > 0) chk(addr_data == addrq[0], "R3 addr head", addr_data, addrq[0]);
      chk(depth == m_depth(), "R4/R5 depth", depth, m_depth());
      chk(start == m_start(), "R5 start", start, m_start());
      chk(ovf == (mcnt > 256), "R5 overflow", ovf, mcnt > 256);
    end
  end

  task automatic cs_on();
    @(negedge clk); cs = 1'b1;
  endtask

  task automatic cs_off();
    @(negedge clk); in_valid = 1'b0; cs = 1'b0; mst = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    model_byte(b);
  endtask

  task automatic send_cmd(input logic [31:0] addr, input bit four, input int n, input int seed);
    a4 = four;
    cs_on();
    send(8'h02);
    if (four) send(addr[31:24]);
    send(addr[23:16]); send(addr[15:8]); send(addr[7:0]);
    for (int i = 0; i < n; i++) send(8'((i * seed + (i >> 8) + 3) & 255));
    cs_off();
  endtask

  task automatic pop_both();
    @(negedge clk); cmd_ready = 1'b1; addr_ready = 1'b1;
    if (cmdq.size() > 0) begin
      chk(cmd_data == cmdq[0], "R9 popped cmd", cmd_data, cmdq[0]); void'(cmdq.pop_front());
    end
    if (addrq.size() > 0) begin
      chk(addr_data == addrq[0], "R3 popped addr", addr_data, addrq[0]); void'(addrq.pop_front());
    end
    @(negedge clk); cmd_ready = 1'b0; addr_ready = 1'b0;
  endtask

  task automatic read_back(input string tag);
    int d = m_depth(), s = m_start();
    for (int i = 0; i < d; i++) begin
      int idx = (s + i) % 256;
      logic [7:0] got, exp;
      @(negedge clk); rd_addr = 6'(idx / 4);
      @(negedge clk); got = rd_data[8*(idx%4) +: 8];
      exp = sent[sent.size() - d + i];
      chk(got == exp, tag, got, exp);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cmd_count == 0 && addr_count == 0, "R1 fifo empty", cmd_count, 0);
    chk(depth == 0 && start == 0 && !ovf, "R1 payload clear", depth, 0);

    // R4: below region size, 3-byte address
    send_cmd(32'h00AB_CDEF, 1'b0, 255, 1);
    chk(depth == 255 && !ovf && start == 0, "R4 255 bytes", depth, 255);
    read_back("R6 readback 255");
    chk(addr_data == 32'h00AB_CDEF, "R3 three-byte addr", addr_data, 32'h00AB_CDEF);
    pop_both();

    // R4 boundary: exactly full
    send_cmd(32'h0000_0000, 1'b0, 256, 5);
    chk(depth == 256 && !ovf && start == 0, "R4 256 bytes", depth, 256);
    read_back("R6 readback 256");
    pop_both();

    // R5: one wrap, 4-byte address
    send_cmd(32'h1234_5678, 1'b1, 300, 7);
    chk(ovf && depth == 256 && start == 44, "R5 300 bytes start", start, 44);
    chk(addr_data == 32'h1234_5678, "R3 four-byte addr", addr_data, 32'h1234_5678);
    read_back("R6 readback 300");
    pop_both();

    // R5/R7: multiple wraps
    send_cmd(32'h0000_0100, 1'b0, 600, 13);
    chk(ovf && start == 88, "R5 600 bytes start", start, 88);
    read_back("R6 readback 600");

    // R2: foreign opcode ignored
    cs_on(); send(8'h03); send(8'h11); send(8'h22); send(8'h33); send(8'h44); cs_off();
    chk(cmd_count == 1 && depth == 256 && start == 88, "R2 ignored opcode", cmd_count, 1);
    read_back("R2 payload untouched");
    pop_both();

    // R7/R6: short payload clears previous overflow, lanes within partial word
    send_cmd(32'h0000_0040, 1'b0, 5, 9);
    chk(!ovf && depth == 5 && start == 0, "R7 state cleared", depth, 5);
    @(negedge clk); rd_addr = 6'd1;
    @(negedge clk);
    chk(rd_data[7:0] == sent[4], "R6 lane0 word1", rd_data[7:0], sent[4]);
    @(negedge clk); rd_addr = 6'd0;
    @(negedge clk);
    chk(rd_data == {sent[3], sent[2], sent[1], sent[0]}, "R11 word0 read",
        rd_data, {sent[3], sent[2], sent[1], sent[0]});
    pop_both();

    // R10: deselect inside the address phase
    a4 = 1'b0;
    cs_on(); send(8'h02); send(8'hAA); cs_off();
    chk(cmd_count == 1 && addr_count == 0, "R10 partial addr dropped", addr_count, 0);
    send_cmd(32'h0055_6677, 1'b0, 2, 3);
    chk(addr_count == 1 && addr_data == 32'h0055_6677, "R10 restart parse", addr_data, 32'h0055_6677);
    pop_both(); pop_both();

    // R8: fill both FIFOs, then the opcode must wait
    for (int k = 0; k < 4; k++) send_cmd(32'h0000_0010 + k, 1'b0, 1, 1);
    chk(cmd_count == 4 && addr_count == 4, "R8 fifos full", cmd_count, 4);
    cs_on();
    fork
      send(8'h02);
      begin
        repeat (8) @(negedge clk);
        chk(!in_ready, "R8 opcode held", in_ready, 0);
        pop_both();
      end
    join
    send(8'h01); send(8'h02); send(8'h03);
    cs_off();
    chk(cmd_count == 4 && addr_count == 4, "R8 opcode accepted after pop", cmd_count, 4);
    repeat (4) pop_both();
    chk(cmd_count == 0 && !cmd_valid, "R9 drained", cmd_count, 0);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule : upload_capture_tb